// File: doc/BRIEF.md
# Asynchronous SRAM Cycle Controller

This block sits between a synchronous host and a 16K x 4 asynchronous static RAM. The host hands over one request at a time, a read or a write with a 14-bit address and 4-bit write data. The controller turns each request into a pin-level cycle on the RAM's two active-low selects, its active-low write and output strobes and its shared 4-bit data bus. Every wait is a count of clock periods. Each count comes from a nanosecond timing parameter divided by the clock period, rounded up, with a floor of one clock.

The request side is a valid/ready stream. A request moves only on a clock edge where `req_valid` and `req_ready` are both high. While `req_ready` is low the host must hold its request steady, and nothing is taken. `req_ready` rises only once the RAM is idle and the turnaround time has passed. A request presented in that same cycle is accepted at the next edge, so requests can follow each other with no gap. Read data comes back as a single-cycle `rsp_valid` pulse and has no back-pressure. The host must be able to take it.

A level input, `retain_req`, parks the RAM deselected for low-power retention. When it falls, the controller waits one full read cycle time before it accepts work again.

Top module: `sram_cycle_ctrl`

## Requirements
- R1: A synchronous reset drives `mem_sel1_n`, `mem_sel2_n`, `mem_we_n` and `mem_oe_n` high, releases the data bus, clears `rsp_valid` and leaves `req_ready` high.
- R2: A request is taken only on an edge where `req_valid` and `req_ready` are both high. A request held while `req_ready` is low starts no RAM cycle, and it is taken at the first edge after `req_ready` rises.
- R3: A write (`req_write`=1) holds both selects low and `mem_we_n` low for ceil(T_WP_NS/T_CLK_NS) clocks, minimum one. During that time `mem_oe_n` stays high and address and data stay steady. The written nibble is driven throughout.
- R4: A read (`req_write`=0) holds both selects and `mem_oe_n` low with `mem_we_n` high. It samples `mem_dq` at the edge ceil(max(T_AA_NS,T_OE_NS)/T_CLK_NS) clocks after those pins change. That sample appears on `rsp_rdata` with `rsp_valid` high for exactly one cycle.
- R5: After each access, all four strobes stay high for ceil(T_TURN_NS/T_CLK_NS) clocks before `req_ready` returns. After a write, the data stays driven during that window. `mem_oe_n` is never low while the controller drives the bus.
- R6: While `retain_req` is high and the controller is idle, both selects stay high and `req_ready` is low. Requests offered then are ignored and leave the RAM contents unchanged.
- R7: After `retain_req` falls, `req_ready` stays low and the RAM stays deselected for ceil(T_RC_NS/T_CLK_NS) clocks.
- R8: A read and a write issued back to back each take exactly their access, turnaround and handshake clocks, with no idle cycle between them. Data written at the lowest and highest addresses reads back intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 14 | Request address |
| req_wdata | input | 4 | Write data |
| rsp_valid | output | 1 | One-cycle read data strobe |
| rsp_rdata | output | 4 | Read data |
| retain_req | input | 1 | Hold RAM deselected for retention |
| mem_addr | output | 14 | RAM address |
| mem_sel1_n | output | 1 | RAM select one, active low |
| mem_sel2_n | output | 1 | RAM select two, active low |
| mem_we_n | output | 1 | RAM write strobe, active low |
| mem_oe_n | output | 1 | RAM output strobe, active low |
| mem_dq | inout | 4 | Shared RAM data bus |

## Verification
A wait counter that is loaded wrong shows up first on the strobes. A write pulse comes out one clock short or long, or the read strobe stays low one clock too long. In a read, the `rsp_valid` pulse also moves off its expected cycle within the same transaction. A read that samples too early picks up the inverted nibble that the bench RAM drives before its access window has elapsed, so it fails at the very first `rsp_valid`. A state machine that drops the turnaround or the recovery wait raises `req_ready` a clock early. A data driver released too soon after a write is seen at the next clock as a wrong bus value.

// File: rtl/sram_ctrl_pkg.sv
`timescale 1ns/1ps
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_WRITE,
    ST_TURN,
    ST_RETAIN,
    ST_RECOVER
  } ctrl_state_e;

  // Nanoseconds to whole clocks, rounded up, never below one clock.
  function automatic int unsigned ns_to_clk(input int unsigned ns, input int unsigned clk_ns);
    int unsigned c;
    c = (ns + clk_ns - 1) / clk_ns;
    return (c == 0) ? 1 : c;
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_wait_timer.sv
`timescale 1ns/1ps
module sram_wait_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             done
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)               cnt_q <= '0;
    else if (load)         cnt_q <= load_val;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign done = (cnt_q == '0);
endmodule

// File: rtl/sram_bus_port.sv
`timescale 1ns/1ps
module sram_bus_port #(
  parameter int ADDR_W = 14,
  parameter int DATA_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic [DATA_W-1:0] load_data,
  input  logic              drive_nxt,
  input  logic              capture,
  output logic [ADDR_W-1:0] mem_addr,
  inout  wire  [DATA_W-1:0] mem_dq,
  output logic [DATA_W-1:0] rdata,
  output logic              drive
);
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdat_q;
  logic [DATA_W-1:0] rdat_q;
  logic              drv_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
      wdat_q <= '0;
      rdat_q <= '0;
      drv_q  <= 1'b0;
    end else begin
      drv_q <= drive_nxt;
      if (load) begin
        addr_q <= load_addr;
        wdat_q <= load_data;
      end
      if (capture) rdat_q <= mem_dq;
    end
  end

  assign mem_dq   = drv_q ? wdat_q : {DATA_W{1'bz}};
  assign mem_addr = addr_q;
  assign rdata    = rdat_q;
  assign drive    = drv_q;
endmodule

// File: rtl/sram_cycle_ctrl.sv
`timescale 1ns/1ps
module sram_cycle_ctrl #(
  parameter int ADDR_W    = 14,
  parameter int DATA_W    = 4,
  parameter int T_CLK_NS  = 20,
  parameter int T_AA_NS   = 20,
  parameter int T_OE_NS   = 9,
  parameter int T_WP_NS   = 15,
  parameter int T_TURN_NS = 5,
  parameter int T_RC_NS   = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  input  logic              retain_req,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_sel1_n,
  output logic              mem_sel2_n,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  inout  wire  [DATA_W-1:0] mem_dq
);
  import sram_ctrl_pkg::*;

  localparam int unsigned AA_CYC   = ns_to_clk(T_AA_NS, T_CLK_NS);
  localparam int unsigned OE_CYC   = ns_to_clk(T_OE_NS, T_CLK_NS);
  localparam int unsigned RD_CYC   = max2(AA_CYC, OE_CYC);
  localparam int unsigned WP_CYC   = ns_to_clk(T_WP_NS, T_CLK_NS);
  localparam int unsigned TURN_CYC = ns_to_clk(T_TURN_NS, T_CLK_NS);
  localparam int unsigned RC_CYC   = ns_to_clk(T_RC_NS, T_CLK_NS);
  localparam int unsigned MAX_CYC  = max2(max2(RD_CYC, WP_CYC), max2(TURN_CYC, RC_CYC));
  localparam int          CNT_W    = (MAX_CYC < 2) ? 1 : $clog2(MAX_CYC);

  localparam logic [CNT_W-1:0] RD_LD   = CNT_W'(RD_CYC - 1);
  localparam logic [CNT_W-1:0] WP_LD   = CNT_W'(WP_CYC - 1);
  localparam logic [CNT_W-1:0] TURN_LD = CNT_W'(TURN_CYC - 1);
  localparam logic [CNT_W-1:0] RC_LD   = CNT_W'(RC_CYC - 1);

  ctrl_state_e st, st_nxt;
  logic             op_wr_q;
  logic             sel_n_q, we_n_q, oe_n_q;
  logic             sel_n_nxt, we_n_nxt, oe_n_nxt;
  logic             tload, tdone;
  logic [CNT_W-1:0] tval;
  logic             accept, drv_nxt, cap, bus_drive;
  logic             rsp_q;

  sram_wait_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst(rst), .load(tload), .load_val(tval), .done(tdone)
  );

  sram_bus_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_bus (
    .clk(clk), .rst(rst), .load(accept), .load_addr(req_addr),
    .load_data(req_wdata), .drive_nxt(drv_nxt), .capture(cap),
    .mem_addr(mem_addr), .mem_dq(mem_dq), .rdata(rsp_rdata), .drive(bus_drive)
  );

  assign req_ready = (st == ST_IDLE) && !retain_req;
  assign accept    = req_valid && req_ready;

  always_comb begin
    st_nxt    = st;
    tload     = 1'b0;
    tval      = '0;
    sel_n_nxt = 1'b1;
    we_n_nxt  = 1'b1;
    oe_n_nxt  = 1'b1;
    drv_nxt   = 1'b0;
    cap       = 1'b0;
    unique case (st)
      ST_IDLE: begin
        if (retain_req) begin
          st_nxt = ST_RETAIN;
        end else if (accept) begin
          tload     = 1'b1;
          sel_n_nxt = 1'b0;
          if (req_write) begin
            st_nxt   = ST_WRITE;
            tval     = WP_LD;
            we_n_nxt = 1'b0;
            drv_nxt  = 1'b1;
          end else begin
            st_nxt   = ST_READ;
            tval     = RD_LD;
            oe_n_nxt = 1'b0;
          end
        end
      end
      ST_READ: begin
        if (tdone) begin
          cap    = 1'b1;
          st_nxt = ST_TURN;
          tload  = 1'b1;
          tval   = TURN_LD;
        end else begin
          sel_n_nxt = 1'b0;
          oe_n_nxt  = 1'b0;
        end
      end
      ST_WRITE: begin
        drv_nxt = 1'b1;
        if (tdone) begin
          st_nxt = ST_TURN;
          tload  = 1'b1;
          tval   = TURN_LD;
        end else begin
          sel_n_nxt = 1'b0;
          we_n_nxt  = 1'b0;
        end
      end
      ST_TURN: begin
        if (tdone) st_nxt = ST_IDLE;
        else       drv_nxt = op_wr_q;
      end
      ST_RETAIN: begin
        if (!retain_req) begin
          st_nxt = ST_RECOVER;
          tload  = 1'b1;
          tval   = RC_LD;
        end
      end
      ST_RECOVER: begin
        if (tdone) st_nxt = ST_IDLE;
      end
      default: st_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_IDLE;
      op_wr_q <= 1'b0;
      sel_n_q <= 1'b1;
      we_n_q  <= 1'b1;
      oe_n_q  <= 1'b1;
      rsp_q   <= 1'b0;
    end else begin
      st      <= st_nxt;
      sel_n_q <= sel_n_nxt;
      we_n_q  <= we_n_nxt;
      oe_n_q  <= oe_n_nxt;
      rsp_q   <= cap;
      if (accept) op_wr_q <= req_write;
    end
  end

  // Both selects come from one decode: the RAM is addressed only when both are low.
  assign mem_sel1_n = sel_n_q;
  assign mem_sel2_n = sel_n_q;
  assign mem_we_n   = we_n_q;
  assign mem_oe_n   = oe_n_q;
  assign rsp_valid  = rsp_q;
endmodule

// File: rtl/sram_cycle_ctrl_checker.sv
`timescale 1ns/1ps
module sram_cycle_ctrl_checker #(
  parameter int ADDR_W = 14
) (
  input logic                      clk,
  input logic                      rst,
  input logic                      req_ready,
  input logic                      rsp_valid,
  input logic [ADDR_W-1:0]         mem_addr,
  input logic                      mem_sel1_n,
  input logic                      mem_sel2_n,
  input logic                      mem_we_n,
  input logic                      mem_oe_n,
  input logic                      bus_drive,
  input sram_ctrl_pkg::ctrl_state_e st
);
  import sram_ctrl_pkg::*;

  p_reset_pins_r1: assert property (@(posedge clk)
    rst |=> (mem_sel1_n && mem_sel2_n && mem_we_n && mem_oe_n && !bus_drive && !rsp_valid));

  p_ready_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> (mem_sel1_n && mem_we_n && mem_oe_n && !bus_drive));

  p_write_pins_r3: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |-> (!mem_sel1_n && !mem_sel2_n && mem_oe_n && bus_drive));

  p_write_addr_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (!mem_we_n && $past(!mem_we_n)) |-> $stable(mem_addr));

  p_read_pins_r4: assert property (@(posedge clk) disable iff (rst)
    !mem_oe_n |-> (mem_we_n && !mem_sel1_n && !mem_sel2_n));

  p_rsp_single_r4: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

  p_no_contend_r5: assert property (@(posedge clk) disable iff (rst)
    bus_drive |-> mem_oe_n);

  p_retain_desel_r6: assert property (@(posedge clk) disable iff (rst)
    (st == ST_RETAIN) |-> (mem_sel1_n && mem_sel2_n && !req_ready));

  p_recover_desel_r7: assert property (@(posedge clk) disable iff (rst)
    (st == ST_RECOVER) |-> (mem_sel1_n && mem_sel2_n && !req_ready));
endmodule

bind sram_cycle_ctrl sram_cycle_ctrl_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .req_ready(req_ready), .rsp_valid(rsp_valid),
  .mem_addr(mem_addr), .mem_sel1_n(mem_sel1_n), .mem_sel2_n(mem_sel2_n),
  .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .bus_drive(bus_drive), .st(st)
);

// File: tb/test_sram_cycle_ctrl.sv
`timescale 1ns/1ps
module test_sram_cycle_ctrl;
  localparam int CLK_NS   = 20;
  localparam int RD_CYC   = 3;  // ceil(max(55,25)/20)
  localparam int WP_CYC   = 2;  // ceil(35/20)
  localparam int TURN_CYC = 1;  // ceil(10/20)
  localparam int RC_CYC   = 4;  // ceil(70/20)

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0, req_write = 1'b0, retain_req = 1'b0;
  logic [13:0] req_addr = '0;
  logic [3:0]  req_wdata = '0;
  logic req_ready, rsp_valid;
  logic [3:0] rsp_rdata;
  logic [13:0] mem_addr;
  logic mem_sel1_n, mem_sel2_n, mem_we_n, mem_oe_n;
  wire  [3:0] mem_dq;

  int vectors = 0;
  int miscompares = 0;
  int viol = 0;

  always #(CLK_NS/2) clk = ~clk;

  sram_cycle_ctrl #(
    .T_CLK_NS(CLK_NS), .T_AA_NS(55), .T_OE_NS(25), .T_WP_NS(35),
    .T_TURN_NS(10), .T_RC_NS(70)
  ) i_sram_cycle_ctrl (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .retain_req(retain_req),
    .mem_addr(mem_addr), .mem_sel1_n(mem_sel1_n), .mem_sel2_n(mem_sel2_n),
    .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .mem_dq(mem_dq)
  );

  // ---------------- behavioural RAM model (low 8 address bits stored) -------
  logic [3:0]  ram [256];
  logic [13:0] p_addr = '0;
  logic        p_sel = 1'b1, p_oe = 1'b1, p_we = 1'b1;
  int          age = 0, wcnt = 0, since_we = 99;
  logic        rd_ok = 1'b0;
  logic [7:0]  w_a = '0;
  logic [3:0]  w_d = '0;
  logic        m_drive;
  logic        sel_act;

  assign sel_act = !mem_sel1_n && !mem_sel2_n;
  assign m_drive = sel_act && !mem_oe_n && mem_we_n;
  assign mem_dq  = m_drive ? (rd_ok ? ram[mem_addr[7:0]] : ~ram[mem_addr[7:0]]) : 4'bz;

  initial for (int i = 0; i < 256; i++) ram[i] = 4'h0;

  always @(negedge clk) begin
    if (mem_addr != p_addr || sel_act == p_sel || mem_oe_n != p_oe) age = 0;
    else if (age < 1000) age = age + 1;
    rd_ok = (age >= RD_CYC - 1);
    if (mem_we_n && !p_we) since_we = 0;
    else if (since_we < 99) since_we = since_we + 1;
    // contention: RAM output enabled while controller may still hold the bus
    if (m_drive && (!mem_we_n || since_we < TURN_CYC)) viol = viol + 1;
    if (sel_act && !mem_we_n) begin
      if (wcnt > 0 && mem_addr[7:0] != w_a) viol = viol + 1;
      wcnt = wcnt + 1;
      w_a  = mem_addr[7:0];
      w_d  = mem_dq;
    end else if (mem_we_n && !p_we) begin
      if (wcnt < WP_CYC) viol = viol + 1;
      ram[w_a] = w_d;
      wcnt = 0;
    end
    p_addr = mem_addr;
    p_sel  = !sel_act;
    p_oe   = mem_oe_n;
    p_we   = mem_we_n;
  end

  // ---------------- checking helpers ----------------------------------------
  task automatic check(input string tag, input bit ok, input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h @%0t", tag, act, exp, $time);
    end
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 strobes high", mem_sel1_n && mem_sel2_n && mem_we_n && mem_oe_n,
          {mem_sel1_n, mem_sel2_n, mem_we_n, mem_oe_n}, 4'hF);
    check("R1 rsp_valid low", !rsp_valid, rsp_valid, 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 ready after reset", req_ready, req_ready, 1);
  endtask

  // Called at a negedge with the controller idle; returns at the negedge
  // where req_ready is high again.
  task automatic do_write(input logic [13:0] a, input logic [3:0] d);
    int we_low = 0;
    check("R2 ready before write", req_ready, req_ready, 1);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    for (int i = 1; i <= WP_CYC + TURN_CYC + 1; i++) begin
      @(negedge clk);
      if (i == 1) req_valid = 1'b0;
      if (!mem_we_n) begin
        we_low++;
        check("R3 data on bus in pulse", mem_dq == d, mem_dq, d);
        check("R3 address in pulse", mem_addr == a, mem_addr, a);
      end
      if (i == WP_CYC + 1) begin
        check("R5 data held after write", mem_dq == d, mem_dq, d);
        check("R5 strobes high in turn", mem_sel1_n && mem_we_n && mem_oe_n,
              {mem_sel1_n, mem_we_n, mem_oe_n}, 3'h7);
      end
      if (i <= WP_CYC + TURN_CYC) check("R5 ready low during write", !req_ready, req_ready, 0);
      else                        check("R5 ready back after write", req_ready, req_ready, 1);
    end
    check("R3 write pulse clocks", we_low == WP_CYC, we_low, WP_CYC);
  endtask

  task automatic do_read(input logic [13:0] a, input logic [3:0] e);
    check("R2 ready before read", req_ready, req_ready, 1);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    for (int i = 1; i <= RD_CYC + TURN_CYC + 1; i++) begin
      @(negedge clk);
      if (i == 1) req_valid = 1'b0;
      if (i <= RD_CYC) begin
        check("R4 read strobes", !mem_oe_n && mem_we_n && !mem_sel1_n && !mem_sel2_n,
              {mem_oe_n, mem_we_n, mem_sel1_n, mem_sel2_n}, 4'b0100);
        check("R4 no early response", !rsp_valid, rsp_valid, 0);
      end
      if (i == RD_CYC + 1) begin
        check("R4 response pulse", rsp_valid, rsp_valid, 1);
        check("R4 read data", rsp_rdata == e, rsp_rdata, e);
        check("R5 oe released", mem_oe_n, mem_oe_n, 1);
      end
      if (i == RD_CYC + 2) check("R4 single pulse", !rsp_valid, rsp_valid, 0);
      if (i <= RD_CYC + TURN_CYC) check("R5 ready low during read", !req_ready, req_ready, 0);
      else                        check("R5 ready back after read", req_ready, req_ready, 1);
    end
  endtask

  task automatic t_basic();
    do_write(14'h0012, 4'hA);
    do_read(14'h0012, 4'hA);
    do_write(14'h0034, 4'h5);
    do_read(14'h0034, 4'h5);
    do_read(14'h0012, 4'hA);
  endtask

  task automatic t_bounds_r8();
    int t0, t1;
    t0 = $time;
    do_write(14'h0000, 4'hF);
    do_write(14'h3FFF, 4'h0);
    do_read(14'h0000, 4'hF);
    do_read(14'h3FFF, 4'h0);
    t1 = $time;
    check("R8 back-to-back span",
          (t1 - t0) == CLK_NS * (2 * (WP_CYC + TURN_CYC + 1) + 2 * (RD_CYC + TURN_CYC + 1)),
          (t1 - t0) / CLK_NS, 2 * (WP_CYC + TURN_CYC + 1) + 2 * (RD_CYC + TURN_CYC + 1));
  endtask

  task automatic t_stall_r2();
    int early = 0;
    req_valid = 1'b1; req_write = 1'b0; req_addr = 14'h0012;
    @(negedge clk);
    // read in flight: offer a write and hold it
    req_write = 1'b1; req_addr = 14'h0056; req_wdata = 4'h9;
    while (!req_ready) begin
      if (!mem_we_n) early++;
      @(negedge clk);
    end
    check("R2 no write while not ready", early == 0, early, 0);
    @(negedge clk);
    req_valid = 1'b0;
    check("R2 held request taken", !mem_we_n, mem_we_n, 0);
    while (!req_ready) @(negedge clk);
    do_read(14'h0056, 4'h9);
  endtask

  task automatic t_retention();
    int bad = 0;
    retain_req = 1'b1;
    req_valid = 1'b1; req_write = 1'b1; req_addr = 14'h0034; req_wdata = 4'hC;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (req_ready || !mem_sel1_n || !mem_sel2_n || !mem_we_n) bad++;
    end
    check("R6 deselected and not ready", bad == 0, bad, 0);
    req_valid = 1'b0;
    retain_req = 1'b0;
    bad = 0;
    for (int i = 1; i <= RC_CYC; i++) begin
      @(negedge clk);
      if (req_ready || !mem_sel1_n) bad++;
    end
    check("R7 recovery wait", bad == 0, bad, 0);
    @(negedge clk);
    check("R7 ready after recovery", req_ready, req_ready, 1);
    do_read(14'h0034, 4'h5);  // R6: ignored write left old value
  endtask

  // ---------------- main + watchdog -----------------------------------------
  initial begin
    t_reset();
    t_basic();
    t_bounds_r8();
    t_stall_r2();
    t_retention();
    check("R3 R4 R5 RAM model timing", viol == 0, viol, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    vectors++;
    miscompares++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule